// File: doc/BRIEF.md
# Upstream Bus Request and Parking Controller

This block runs the request/grant handshake for a bridge port that starts its own transactions on a shared parallel bus. It watches how many upstream transactions are waiting and whether the one at the head has been fully queued. From that it drives an active-low request pin. When the grant comes back it issues a one-cycle start strobe for the data-phase sequencer.

A transaction that ends early, through a target retry, a disconnect or an abort, forces the request off for a fixed back-off window. After that window the request may rise again. When the arbiter grants the bus while no request is out, the block raises a park enable. The park enable tells the pad logic to hold address/data, command/byte-enable and parity at valid levels. A port that is parked in this way may start a transaction at once, without raising the request first. The grant is registered on the bus clock. The start strobe follows from that registered grant.

Top module: `bus_req_park`

## Requirements
- R1: While reset is low, and on the first sample after it, `reqN` is 1, `parkEn` is 0 and `startPulse` is 0.
- R2: The request (`reqN` = 0) is driven only after an edge that sampled `queuedDone` = 1 and a nonzero `pendCount`. Outside back-off and a parked start, it falls on that edge and stays low as long as work is pending, including while a transaction is in flight.
- R3: A termination (`termRetry`, `termDisc` or `termAbort` = 1) sampled while a transaction is in flight holds `reqN` at 1 for exactly `BACKOFF_CYCLES` (default 2) samples, with no start in that window. If work is still pending and the port is not parked, `reqN` falls on the next edge.
- R4: With the request asserted, a `gntN` = 0 sampled at edge E produces `startPulse` = 1 after edge E+1, and not before.
- R5: A grant sampled while no request is out and nothing is in flight sets `parkEn` one edge later. `parkEn` clears one edge after the grant is sampled high again. `parkEn` is never 1 while `reqN` is 0.
- R6: `startPulse` lasts one cycle. No further start is issued until `xferDone` or a termination is sampled.
- R7: When the port is parked, with the grant still sampled, and work becomes ready, `startPulse` rises on the next edge while `reqN` stays 1.
- R8: `xferDone` and the termination inputs have no effect while no transaction is in flight. In particular, a termination then starts no back-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pendCount | input | CNT_W | Number of upstream transactions waiting |
| queuedDone | input | 1 | Head transaction is completely queued |
| gntN | input | 1 | Bus grant, active low |
| xferDone | input | 1 | In-flight transaction completed normally |
| termRetry | input | 1 | In-flight transaction ended by target retry |
| termDisc | input | 1 | In-flight transaction ended by target disconnect |
| termAbort | input | 1 | In-flight transaction ended by target abort |
| reqN | output | 1 | Bus request, active low |
| startPulse | output | 1 | One-cycle strobe that starts a transaction |
| parkEn | output | 1 | Drive address, command and parity to valid levels |

## Verification
Each result has a fixed latency. Request and park enable follow their cause by one edge. The start strobe comes two edges after the grant is driven, because the grant passes through a register first. A parked start comes one edge after work becomes ready. Back-off holds the request off for two samples after the terminating edge. The bench drives inputs and samples outputs on the falling edge, and places each check on the exact sample where that count says the output changes. It also checks the sample before, where the output must not have moved yet. Grant-delay and termination-type sweeps repeat these checks across every starting condition.

// File: rtl/brq_pkg.sv
package brq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBackoff;
  } brqStrobe_t;

  // Conditions reported by the datapath to control
  typedef struct packed {
    logic workReady;
    logic grantSeen;
    logic backoffBusy;
  } brqStatus_t;

endpackage

// File: rtl/brq_datapath.sv
module brq_datapath
  import brq_pkg::*;
#(
  parameter int CNT_W          = 4,
  parameter int BACKOFF_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pendCount,
  input  logic             queuedDone,
  input  logic             gntN,
  input  brqStrobe_t       strobe,
  output brqStatus_t       status
);

  localparam int BO_W = $clog2(BACKOFF_CYCLES + 1);
  localparam logic [BO_W-1:0] BO_LOAD = BO_W'(BACKOFF_CYCLES - 1);

  logic            grantQ;
  logic [BO_W-1:0] boCnt;

  // Grant is registered before any decision uses it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grantQ <= 1'b0;
    else       grantQ <= ~gntN;
  end

  // Back-off counter: the terminating cycle itself blocks via control,
  // the counter covers the remaining cycles of the window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   boCnt <= '0;
    else if (strobe.loadBackoff) boCnt <= BO_LOAD;
    else if (boCnt != '0)        boCnt <= boCnt - 1'b1;
  end

  always_comb begin
    status.workReady   = queuedDone && (pendCount != '0);
    status.grantSeen   = grantQ;
    status.backoffBusy = (boCnt != '0);
  end

endmodule

// File: rtl/brq_control.sv
module brq_control
  import brq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  brqStatus_t status,
  input  logic       xferDone,
  input  logic       termRetry,
  input  logic       termDisc,
  input  logic       termAbort,
  output brqStrobe_t strobe,
  output logic       reqOn,
  output logic       startPulse,
  output logic       parkEn
);

  logic busyQ, reqOnQ, parkQ, startQ;
  logic termNow, endNow, startNow, parkStart;
  logic reqOnNext, parkNext, busyNext;

  always_comb begin
    termNow   = busyQ && (termRetry || termDisc || termAbort);
    endNow    = busyQ && xferDone;
    startNow  = !busyQ && status.workReady && !status.backoffBusy &&
                status.grantSeen && (reqOnQ || parkQ);
    parkStart = startNow && !reqOnQ;
    reqOnNext = status.workReady && !termNow && !status.backoffBusy && !parkStart;
    parkNext  = status.grantSeen && !busyQ && !startNow && !reqOnNext && !reqOnQ;
    if (startNow)             busyNext = 1'b1;
    else if (termNow || endNow) busyNext = 1'b0;
    else                      busyNext = busyQ;
    strobe.loadBackoff = termNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      reqOnQ <= 1'b0;
      parkQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      busyQ  <= busyNext;
      reqOnQ <= reqOnNext;
      parkQ  <= parkNext;
      startQ <= startNow;
    end
  end

  assign reqOn      = reqOnQ;
  assign startPulse = startQ;
  assign parkEn     = parkQ;

endmodule

// File: rtl/bus_req_park.sv
module bus_req_park
  import brq_pkg::*;
#(
  parameter int CNT_W          = 4,
  parameter int BACKOFF_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pendCount,
  input  logic             queuedDone,
  input  logic             gntN,
  input  logic             xferDone,
  input  logic             termRetry,
  input  logic             termDisc,
  input  logic             termAbort,
  output logic             reqN,
  output logic             startPulse,
  output logic             parkEn
);

  brqStrobe_t strobe;
  brqStatus_t status;
  logic       reqOn;

  brq_datapath #(
    .CNT_W(CNT_W),
    .BACKOFF_CYCLES(BACKOFF_CYCLES)
  ) u_datapath (
    .clk(clk),
    .rstN(rstN),
    .pendCount(pendCount),
    .queuedDone(queuedDone),
    .gntN(gntN),
    .strobe(strobe),
    .status(status)
  );

  brq_control u_control (
    .clk(clk),
    .rstN(rstN),
    .status(status),
    .xferDone(xferDone),
    .termRetry(termRetry),
    .termDisc(termDisc),
    .termAbort(termAbort),
    .strobe(strobe),
    .reqOn(reqOn),
    .startPulse(startPulse),
    .parkEn(parkEn)
  );

  assign reqN = ~reqOn;

endmodule

// File: rtl/bus_req_park_checker.sv
module bus_req_park_checker #(
  parameter int CNT_W          = 4,
  parameter int BACKOFF_CYCLES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] pendCount,
  input logic             queuedDone,
  input logic             gntN,
  input logic             xferDone,
  input logic             termRetry,
  input logic             termDisc,
  input logic             termAbort,
  input logic             reqN,
  input logic             startPulse,
  input logic             parkEn
);

  localparam int BO_W = $clog2(BACKOFF_CYCLES + 1);

  logic            inFlight;
  logic [BO_W-1:0] boWin;
  logic            termAny;

  assign termAny = termRetry || termDisc || termAbort;

  // Shadow of the in-flight state, built from the ports only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               inFlight <= 1'b0;
    else if (startPulse)                     inFlight <= 1'b1;
    else if (inFlight && (xferDone || termAny)) inFlight <= 1'b0;
  end

  // Back-off window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      boWin <= '0;
    else if (inFlight && termAny)   boWin <= BO_W'(BACKOFF_CYCLES);
    else if (boWin != '0)           boWin <= boWin - 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (reqN && !parkEn && !startPulse));

  p_req_needs_work_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(queuedDone && (pendCount != '0)) |=> reqN);

  p_backoff_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (boWin != '0) |-> reqN);

  p_backoff_nostart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (boWin != '0) |-> !startPulse);

  p_start_after_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> ($past(gntN, 2) == 1'b0));

  p_park_no_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    parkEn |-> reqN);

  p_single_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  p_busy_no_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !startPulse);

endmodule

bind bus_req_park bus_req_park_checker #(
  .CNT_W(CNT_W),
  .BACKOFF_CYCLES(BACKOFF_CYCLES)
) u_checker (
  .clk(clk),
  .rstN(rstN),
  .pendCount(pendCount),
  .queuedDone(queuedDone),
  .gntN(gntN),
  .xferDone(xferDone),
  .termRetry(termRetry),
  .termDisc(termDisc),
  .termAbort(termAbort),
  .reqN(reqN),
  .startPulse(startPulse),
  .parkEn(parkEn)
);

// File: tb/test_bus_req_park.sv
module test_bus_req_park;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic [CNT_W-1:0] pendCount;
  logic             queuedDone, gntN, xferDone;
  logic             termRetry, termDisc, termAbort;
  logic             reqN, startPulse, parkEn;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bus_req_park #(.CNT_W(CNT_W), .BACKOFF_CYCLES(2)) i_bus_req_park (
    .clk(clk), .rstN(rstN), .pendCount(pendCount), .queuedDone(queuedDone),
    .gntN(gntN), .xferDone(xferDone), .termRetry(termRetry),
    .termDisc(termDisc), .termAbort(termAbort),
    .reqN(reqN), .startPulse(startPulse), .parkEn(parkEn)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    rstN = 1'b0; pendCount = '0; queuedDone = 1'b0; gntN = 1'b1;
    xferDone = 1'b0; termRetry = 1'b0; termDisc = 1'b0; termAbort = 1'b0;
    repeat (3) step();
    chk("R1 reqN in reset", reqN, 1'b1);
    chk("R1 parkEn in reset", parkEn, 1'b0);
    chk("R1 startPulse in reset", startPulse, 1'b0);
    rstN = 1'b1;
    step();
    chk("R1 reqN after reset", reqN, 1'b1);

    // R2: pending but not queued, then queued but nothing pending
    pendCount = 4'd3; queuedDone = 1'b0;
    repeat (3) step();
    chk("R2 not queued", reqN, 1'b1);
    pendCount = 4'd0; queuedDone = 1'b1;
    step();
    chk("R2 nothing pending", reqN, 1'b1);
    pendCount = 4'd3;
    step();
    chk("R2 request on ready", reqN, 1'b0);

    // R4/R6: grant delay sweep
    for (int d = 0; d < 4; d++) begin
      repeat (d) step();
      chk("R2 held before grant", reqN, 1'b0);
      gntN = 1'b0;
      step();
      chk("R4 no start one edge after grant", startPulse, 1'b0);
      step();
      chk("R4 start two edges after grant", startPulse, 1'b1);
      chk("R2 held in flight", reqN, 1'b0);
      gntN = 1'b1;
      step();
      chk("R6 single cycle start", startPulse, 1'b0);
      gntN = 1'b0;
      step();
      step();
      chk("R6 no start while in flight", startPulse, 1'b0);
      gntN = 1'b1; xferDone = 1'b1;
      step();
      xferDone = 1'b0;
      chk("R6 no start on completion edge", startPulse, 1'b0);
      chk("R2 still requesting after completion", reqN, 1'b0);
    end

    // R3: termination type sweep, grant held off (g=0) or on (g=1)
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 3; k++) begin
        gntN = 1'b0;
        step();
        step();
        chk("R4 start before termination", startPulse, 1'b1);
        gntN = 1'b1;
        step();
        termRetry = (k == 0); termDisc = (k == 1); termAbort = (k == 2);
        if (g == 1) gntN = 1'b0;
        step();
        termRetry = 1'b0; termDisc = 1'b0; termAbort = 1'b0;
        chk("R3 backoff sample 1 reqN", reqN, 1'b1);
        chk("R3 backoff sample 1 start", startPulse, 1'b0);
        chk("R5 no park while in flight", parkEn, 1'b0);
        step();
        chk("R3 backoff sample 2 reqN", reqN, 1'b1);
        chk("R3 backoff sample 2 start", startPulse, 1'b0);
        chk("R5 park during backoff with grant", parkEn, logic'(g == 1));
        step();
        if (g == 0) begin
          chk("R3 request after backoff", reqN, 1'b0);
          chk("R3 no start without grant", startPulse, 1'b0);
        end else begin
          chk("R7 parked start after backoff", startPulse, 1'b1);
          chk("R7 no request before parked start", reqN, 1'b1);
          chk("R5 park cleared by start", parkEn, 1'b0);
          gntN = 1'b1;
          step();
          chk("R2 request while in flight", reqN, 1'b0);
          xferDone = 1'b1;
          step();
          xferDone = 1'b0;
        end
      end
    end

    // R5/R7: parking
    pendCount = 4'd0;
    step();
    chk("R2 request drops without work", reqN, 1'b1);
    gntN = 1'b0;
    step();
    chk("R5 park not yet", parkEn, 1'b0);
    step();
    chk("R5 parked", parkEn, 1'b1);
    chk("R5 parked without request", reqN, 1'b1);
    gntN = 1'b1;
    step();
    chk("R5 park holds one edge", parkEn, 1'b1);
    step();
    chk("R5 park released", parkEn, 1'b0);
    gntN = 1'b0;
    step();
    step();
    chk("R5 parked again", parkEn, 1'b1);
    pendCount = 4'd2;
    step();
    chk("R7 immediate start when parked", startPulse, 1'b1);
    chk("R7 request stays off", reqN, 1'b1);
    chk("R7 park ends on start", parkEn, 1'b0);
    gntN = 1'b1;
    step();
    chk("R6 single start after park", startPulse, 1'b0);
    chk("R2 request in flight after parked start", reqN, 1'b0);
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;

    // R8: termination and completion ignored while idle
    step();
    chk("R8 requesting before idle termination", reqN, 1'b0);
    termAbort = 1'b1; xferDone = 1'b1;
    step();
    termAbort = 1'b0; xferDone = 1'b0;
    chk("R8 idle termination no backoff", reqN, 1'b0);
    step();
    chk("R8 request still on", reqN, 1'b0);
    chk("R8 no spurious start", startPulse, 1'b0);

    finish();
  end

endmodule